// File: doc/BRIEF.md
# Post-Increment Load Unit

This unit executes loads whose memory address is the base register value itself, taken unmodified. Only after the read does it form a new base by adding an offset, and it writes that sum back to the base register. The offset is one of three kinds: a signed 16-bit immediate, a signed 14-bit immediate scaled by four, or a second register operand. The loaded data is trimmed to the access size and then zero- or sign-extended into a 64-bit result for the target register.

A decoder hands the unit one operation at a time through a valid/ready handshake. The operation carries both operand values, the immediate and the two register indices. The unit issues one read request and accepts the read data, each through its own valid/ready handshake. It then writes the target register and the base register in the same cycle. An operation whose base index is 0, or whose base index equals the target index, is rejected as an invalid form: no memory traffic, no register writes, and a flagged completion.

Top module: `postinc_load_unit`

## Requirements
- R1: The read address equals `ra_val` as captured when the operation is accepted, with no offset added. `mem_req_size` is the byte count 1, 2, 4 or 8 for `op_size` codes 0, 1, 2 and 3. Address and size stay stable while `mem_req_valid` is high and `mem_req_ready` is low.
- R2: With `op_form` = 0, the base write-back value is `ra_val` plus `imm` sign-extended from bit 15.
- R3: With `op_form` = 1, the base write-back value is `ra_val` plus the value formed by appending two zero bits below `imm[13:0]` and sign-extending from `imm[13]`. Bits `imm[15:14]` have no effect.
- R4: With `op_form` = 2 or 3, the base write-back value is `ra_val` plus `rb_val`.
- R5: With `op_signed` = 0 and `op_size` 0, 1 or 2, `rt_wdata` holds `mem_rsp_data` bits [7:0], [15:0] or [31:0] respectively, with every higher bit cleared.
- R6: With `op_signed` = 1 and `op_size` 1 or 2, the bits of `rt_wdata` above the 16- or 32-bit value are copies of that value's top bit. For `op_size` 0, `op_signed` has no effect and the byte is zero-extended.
- R7: With `op_size` 3, `rt_wdata` equals all 64 bits of `mem_rsp_data`, whatever the value of `op_signed`.
- R8: An operation with `ra_idx` = 0 or `ra_idx` = `rt_idx` produces `done` and `invalid` high in the cycle after acceptance. It raises no memory request and asserts neither write strobe.
- R9: `rt_we`, `ra_we` and `done` are high together, for one cycle, in the cycle after read data is accepted. In that cycle `rt_waddr` = `rt_idx` and `ra_waddr` = `ra_idx`.
- R10: `op_ready` is high only when the unit is idle. It is low from acceptance through the cycle in which `done` is high.
- R11: The base update is computed modulo 2^64 and wraps without any indication.
- R12: A synchronous active-low reset returns the unit to idle: `op_ready` high, and no request, strobe or `done` active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted this cycle if offered |
| op_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| op_signed | input | 1 | Sign-extend the loaded value |
| op_form | input | 2 | Offset kind: 0 imm16, 1 scaled imm14, 2/3 register |
| ra_val | input | 64 | Base register value |
| rb_val | input | 64 | Index register value |
| imm | input | 16 | Immediate field |
| rt_idx | input | 5 | Target register index |
| ra_idx | input | 5 | Base register index |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read address |
| mem_req_size | output | 4 | Bytes to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Unit waiting for read data |
| mem_rsp_data | input | 64 | Read data, right-aligned |
| rt_we | output | 1 | Target write strobe |
| rt_waddr | output | 5 | Target write index |
| rt_wdata | output | 64 | Extended load value |
| ra_we | output | 1 | Base write strobe |
| ra_waddr | output | 5 | Base write index |
| ra_wdata | output | 64 | Updated base value |
| done | output | 1 | Operation complete |
| invalid | output | 1 | Completed operation was an invalid form |

## Verification
The bench sweeps every size, sign and offset-form combination against data patterns whose extension bits are set and clear in turn. Any swap of zero- and sign-fill, or any byte extension that honours the sign flag, therefore shows up as a wrong `rt_wdata`. Offsets are chosen negative, scaled, with stray upper immediate bits, and wrapping past 2^64. A unit that added the offset before the read would show it on `mem_req_addr`, and one that dropped the scaling or the sign would show it on `ra_wdata`. Both invalid-form cases, together with stalled request handshakes, check that a rejected operation produces no request or writes and that the request stays stable while it waits.

// File: rtl/pil_pkg.sv
// Shared encodings for the post-increment load unit.
// Assumes a 2-bit size code and a 2-bit offset-form code from the decoder.
package pil_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        FORM_IMM   = 2'd0,
        FORM_SCALE = 2'd1,
        FORM_REG   = 2'd2,
        FORM_REG2  = 2'd3
    } form_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_WAIT = 3'd2,
        ST_WB   = 3'd3,
        ST_BAD  = 3'd4
    } state_e;
endpackage

// File: rtl/pil_offset.sv
// Computes the updated base: base plus an offset chosen by the form code.
// Assumes immediates arrive in the low bits of imm; the sum wraps modulo 2^XLEN.
module pil_offset #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16,
    parameter int DS_W  = 14
) (
    input  pil_pkg::form_e   form,
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  index,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  sum
);
    localparam int SC_W = DS_W + 2;

    logic [XLEN-1:0] off_imm;
    logic [XLEN-1:0] off_scaled;
    logic [XLEN-1:0] off_sel;

    // Sign-extend the full immediate.
    assign off_imm    = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    // Scale the short immediate by four, then sign-extend it.
    assign off_scaled = {{(XLEN-SC_W){imm[DS_W-1]}}, imm[DS_W-1:0], 2'b00};

    // Pick the offset for this form.
    always_comb begin
        unique case (form)
            pil_pkg::FORM_IMM:   off_sel = off_imm;
            pil_pkg::FORM_SCALE: off_sel = off_scaled;
            default:             off_sel = index;
        endcase
    end

    // Wrapping add; carry out is discarded.
    assign sum = base + off_sel;
endmodule

// File: rtl/pil_extend.sv
// Trims right-aligned read data to the access size and zero- or sign-extends it.
// Assumes the byte lane never sign-extends and the full-width lane passes through.
module pil_extend #(
    parameter int XLEN = 64
) (
    input  pil_pkg::size_e  size,
    input  logic            sgn,
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] value
);
    localparam int NLANE = 4;

    logic [XLEN-1:0] cand [NLANE];

    // One candidate result per access width.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int W = 8 << g;
        if (W >= XLEN) begin : g_full
            assign cand[g] = raw;
        end else if (g == 0) begin : g_byte
            assign cand[g] = {{(XLEN-W){1'b0}}, raw[W-1:0]};
        end else begin : g_part
            assign cand[g] = sgn ? {{(XLEN-W){raw[W-1]}}, raw[W-1:0]}
                                 : {{(XLEN-W){1'b0}}, raw[W-1:0]};
        end
    end

    // Select the lane for the requested size.
    assign value = cand[size];
endmodule

// File: rtl/pil_ctrl.sv
// Sequencer: idle, request, wait for data, write back; or idle, reject.
// Assumes op_bad is valid whenever op_valid is high.
module pil_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic op_bad,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    output logic op_ready,
    output logic op_fire,
    output logic mem_req_valid,
    output logic mem_rsp_ready,
    output logic rsp_fire,
    output logic wb_en,
    output logic done,
    output logic invalid
);
    import pil_pkg::*;

    state_e state, state_nx;

    // Decode outputs from the current state.
    assign op_ready      = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_REQ);
    assign mem_rsp_ready = (state == ST_WAIT);
    assign wb_en         = (state == ST_WB);
    assign invalid       = (state == ST_BAD);
    assign done          = wb_en || invalid;
    assign op_fire       = op_ready && op_valid;
    assign rsp_fire      = mem_rsp_ready && mem_rsp_valid;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (op_valid) state_nx = op_bad ? ST_BAD : ST_REQ;
            ST_REQ:  if (mem_req_ready) state_nx = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) state_nx = ST_WB;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R8
    inv_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> done && !wb_en && !mem_req_valid);
    // R9
    wb_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fire |=> wb_en && done);
    // R10
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !op_ready);
    // R12
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> op_ready && !mem_req_valid && !done);
endmodule

// File: rtl/postinc_load_unit.sv
// Post-increment load unit: reads at the unmodified base, then writes the
// extended data to the target and base plus offset to the base register.
// Assumes one operation in flight and right-aligned read data.
module postinc_load_unit #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5,
    parameter int IMM_W = 16,
    parameter int DS_W  = 14,
    parameter int SZ_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    output logic             op_ready,
    input  logic [1:0]       op_size,
    input  logic             op_signed,
    input  logic [1:0]       op_form,
    input  logic [XLEN-1:0]  ra_val,
    input  logic [XLEN-1:0]  rb_val,
    input  logic [IMM_W-1:0] imm,
    input  logic [IDX_W-1:0] rt_idx,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [XLEN-1:0]  mem_req_addr,
    output logic [SZ_W-1:0]  mem_req_size,
    input  logic             mem_rsp_valid,
    output logic             mem_rsp_ready,
    input  logic [XLEN-1:0]  mem_rsp_data,
    output logic             rt_we,
    output logic [IDX_W-1:0] rt_waddr,
    output logic [XLEN-1:0]  rt_wdata,
    output logic             ra_we,
    output logic [IDX_W-1:0] ra_waddr,
    output logic [XLEN-1:0]  ra_wdata,
    output logic             done,
    output logic             invalid
);
    import pil_pkg::*;

    logic             op_fire;
    logic             rsp_fire;
    logic             wb_en;
    logic             op_bad;
    size_e            q_size;
    logic             q_sgn;
    form_e            q_form;
    logic [XLEN-1:0]  q_base;
    logic [XLEN-1:0]  q_index;
    logic [IMM_W-1:0] q_imm;
    logic [IDX_W-1:0] q_rt;
    logic [IDX_W-1:0] q_ra;
    logic [XLEN-1:0]  ext_val;
    logic [XLEN-1:0]  q_load;

    // Invalid form: base index zero or aliasing the target.
    assign op_bad = (ra_idx == '0) || (ra_idx == rt_idx);

    pil_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_bad        (op_bad),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .op_ready      (op_ready),
        .op_fire       (op_fire),
        .mem_req_valid (mem_req_valid),
        .mem_rsp_ready (mem_rsp_ready),
        .rsp_fire      (rsp_fire),
        .wb_en         (wb_en),
        .done          (done),
        .invalid       (invalid)
    );

    // Capture the operation's operands on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_size  <= SZ_BYTE;
            q_sgn   <= 1'b0;
            q_form  <= FORM_IMM;
            q_base  <= '0;
            q_index <= '0;
            q_imm   <= '0;
            q_rt    <= '0;
            q_ra    <= '0;
        end else if (op_fire) begin
            q_size  <= size_e'(op_size);
            q_sgn   <= op_signed;
            q_form  <= form_e'(op_form);
            q_base  <= ra_val;
            q_index <= rb_val;
            q_imm   <= imm;
            q_rt    <= rt_idx;
            q_ra    <= ra_idx;
        end
    end

    // Request carries the raw base and the byte count.
    assign mem_req_addr = q_base;
    assign mem_req_size = SZ_W'(1) << q_size;

    pil_extend #(.XLEN(XLEN)) u_ext (
        .size  (q_size),
        .sgn   (q_sgn),
        .raw   (mem_rsp_data),
        .value (ext_val)
    );

    // Hold the extended load value from the data handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)        q_load <= '0;
        else if (rsp_fire) q_load <= ext_val;
    end

    pil_offset #(.XLEN(XLEN), .IMM_W(IMM_W), .DS_W(DS_W)) u_off (
        .form  (q_form),
        .base  (q_base),
        .index (q_index),
        .imm   (q_imm),
        .sum   (ra_wdata)
    );

    // Paired write-back outputs.
    assign rt_we    = wb_en;
    assign ra_we    = wb_en;
    assign rt_waddr = q_rt;
    assign ra_waddr = q_ra;
    assign rt_wdata = q_load;

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid
            && $stable(mem_req_addr) && $stable(mem_req_size));
    // R1
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> $onehot0(mem_req_size) && mem_req_size != '0);
    // R9
    wb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we |-> ra_we && done && !invalid);
    // R8
    wb_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ra_we |-> ra_waddr != '0 && ra_waddr != rt_waddr);
endmodule

// File: tb/postinc_load_unit_tb.sv
module postinc_load_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [1:0]  op_size = '0;
    logic        op_signed = 1'b0;
    logic [1:0]  op_form = '0;
    logic [63:0] ra_val = '0;
    logic [63:0] rb_val = '0;
    logic [15:0] imm = '0;
    logic [4:0]  rt_idx = '0;
    logic [4:0]  ra_idx = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic [3:0]  mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [63:0] mem_rsp_data = '0;
    logic        rt_we;
    logic [4:0]  rt_waddr;
    logic [63:0] rt_wdata;
    logic        ra_we;
    logic [4:0]  ra_waddr;
    logic [63:0] ra_wdata;
    logic        done;
    logic        invalid;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    postinc_load_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_size(op_size), .op_signed(op_signed), .op_form(op_form),
        .ra_val(ra_val), .rb_val(rb_val), .imm(imm), .rt_idx(rt_idx),
        .ra_idx(ra_idx), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_req_size(mem_req_size), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
        .rt_we(rt_we), .rt_waddr(rt_waddr), .rt_wdata(rt_wdata),
        .ra_we(ra_we), .ra_waddr(ra_waddr), .ra_wdata(ra_wdata),
        .done(done), .invalid(invalid)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_load(input logic [1:0] sz, input bit sg,
                                             input logic [63:0] d);
        case (sz)
            2'd0:    return {56'd0, d[7:0]};
            2'd1:    return sg ? {{48{d[15]}}, d[15:0]} : {48'd0, d[15:0]};
            2'd2:    return sg ? {{32{d[31]}}, d[31:0]} : {32'd0, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [63:0] exp_base(input logic [1:0] fm, input logic [63:0] a,
                                             input logic [63:0] b, input logic [15:0] im);
        logic [63:0] off;
        case (fm)
            2'd0:    off = {{48{im[15]}}, im};
            2'd1:    off = {{48{im[13]}}, im[13:0], 2'b00};
            default: off = b;
        endcase
        return a + off;
    endfunction

    // Offer one operation at a negedge; it is accepted at the next posedge.
    task automatic offer(input logic [1:0] sz, input bit sg, input logic [1:0] fm,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [15:0] im, input logic [4:0] t, input logic [4:0] r);
        chk(op_ready === 1'b1, "R10 ready when idle", 64'(op_ready), 64'd1);
        op_valid = 1'b1; op_size = sz; op_signed = sg; op_form = fm;
        ra_val = a; rb_val = b; imm = im; rt_idx = t; ra_idx = r;
        @(negedge clk);
        op_valid = 1'b0;
        ra_val = ~a; rb_val = ~b; imm = ~im;
    endtask

    task automatic run_ok(input logic [1:0] sz, input bit sg, input logic [1:0] fm,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic [15:0] im, input logic [4:0] t, input logic [4:0] r,
                          input logic [63:0] d, input int stall);
        logic [63:0] eb;
        logic [63:0] el;
        eb = exp_base(fm, a, b, im);
        el = exp_load(sz, sg, d);
        offer(sz, sg, fm, a, b, im, t, r);
        chk(mem_req_valid === 1'b1, "R1 request raised", 64'(mem_req_valid), 64'd1);
        chk(mem_req_addr === a, "R1 address is base", mem_req_addr, a);
        chk(mem_req_size === (4'd1 << sz), "R1 size code", 64'(mem_req_size), 64'(4'd1 << sz));
        chk(op_ready === 1'b0, "R10 busy", 64'(op_ready), 64'd0);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk(mem_req_valid === 1'b1 && mem_req_addr === a, "R1 stall hold",
                mem_req_addr, a);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(mem_req_valid === 1'b0 && mem_rsp_ready === 1'b1, "R9 waiting for data",
            64'({mem_req_valid, mem_rsp_ready}), 64'b01);
        chk(rt_we === 1'b0 && done === 1'b0, "R9 no early write", 64'({rt_we, done}), 64'd0);
        mem_rsp_valid = 1'b1; mem_rsp_data = d;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = ~d;
        chk(rt_we === 1'b1 && ra_we === 1'b1 && done === 1'b1 && invalid === 1'b0,
            "R9 paired strobes", 64'({rt_we, ra_we, done, invalid}), 64'b1110);
        chk(rt_waddr === t && ra_waddr === r, "R9 write indices",
            64'({rt_waddr, ra_waddr}), 64'({t, r}));
        if (sz == 2'd3)      chk(rt_wdata === el, "R7 full width", rt_wdata, el);
        else if (sg)         chk(rt_wdata === el, "R6 sign fill", rt_wdata, el);
        else                 chk(rt_wdata === el, "R5 zero fill", rt_wdata, el);
        case (fm)
            2'd0:    chk(ra_wdata === eb, "R2 imm16 update", ra_wdata, eb);
            2'd1:    chk(ra_wdata === eb, "R3 scaled update", ra_wdata, eb);
            default: chk(ra_wdata === eb, "R4 indexed update", ra_wdata, eb);
        endcase
        chk(op_ready === 1'b0, "R10 busy at done", 64'(op_ready), 64'd0);
        @(negedge clk);
        chk(rt_we === 1'b0 && done === 1'b0 && op_ready === 1'b1, "R9 single pulse",
            64'({rt_we, done, op_ready}), 64'b001);
    endtask

    task automatic run_bad(input logic [4:0] t, input logic [4:0] r);
        offer(2'd2, 1'b0, 2'd0, 64'h1000, 64'h8, 16'h10, t, r);
        chk(done === 1'b1 && invalid === 1'b1, "R8 flagged", 64'({done, invalid}), 64'b11);
        chk(rt_we === 1'b0 && ra_we === 1'b0 && mem_req_valid === 1'b0,
            "R8 suppressed", 64'({rt_we, ra_we, mem_req_valid}), 64'd0);
        @(negedge clk);
        chk(op_ready === 1'b1 && done === 1'b0 && mem_req_valid === 1'b0,
            "R8 back to idle", 64'({op_ready, done, mem_req_valid}), 64'b100);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [63:0] pats [4];
        logic [63:0] bases [4];
        logic [15:0] imms [4];
        pats[0]  = 64'h0123_4567_89AB_CDEF;
        pats[1]  = 64'hFEDC_BA98_7654_3210;
        pats[2]  = 64'h0000_0000_8000_8080;
        pats[3]  = 64'hFFFF_FFFF_7FFF_7F7F;
        bases[0] = 64'h0000_0000_0001_0000;
        bases[1] = 64'hFFFF_FFFF_FFFF_FFF0;
        bases[2] = 64'h8000_0000_0000_0004;
        bases[3] = 64'h0000_0000_0000_0002;
        imms[0]  = 16'h0040;
        imms[1]  = 16'h8000;
        imms[2]  = 16'hE001;
        imms[3]  = 16'h3FFF;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(op_ready === 1'b1 && mem_req_valid === 1'b0 && rt_we === 1'b0 &&
            ra_we === 1'b0 && done === 1'b0, "R12 reset idle",
            64'({op_ready, mem_req_valid, rt_we, ra_we, done}), 64'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 128; p++) begin
            logic [1:0] sz;
            logic [1:0] fm;
            bit         sg;
            sz = 2'(p % 4);
            sg = 1'((p / 4) % 2);
            fm = 2'((p / 8) % 4);
            run_ok(sz, sg, fm, bases[(p / 32) % 4], 64'h20 + 64'(p) * 64'h1111,
                   imms[(p / 2) % 4], 5'(3 + p % 5), 5'(10 + p % 7),
                   pats[(p / 8) % 4] ^ {56'd0, 8'(p)}, p % 3);
        end
        // R11: explicit wrap through the index form
        run_ok(2'd3, 1'b0, 2'd2, 64'hFFFF_FFFF_FFFF_FFF8, 64'h10, 16'h0, 5'd1, 5'd2,
               64'hDEAD_BEEF_0000_0001, 0);
        // R3: upper immediate bits ignored for the scaled form
        run_ok(2'd3, 1'b1, 2'd1, 64'h100, 64'h0, 16'hC001, 5'd4, 5'd5, 64'h5, 1);
        // R6: byte ignores the sign request
        run_ok(2'd0, 1'b1, 2'd0, 64'h200, 64'h0, 16'h1, 5'd6, 5'd7, 64'hFF, 0);
        // R8: both invalid forms
        run_bad(5'd9, 5'd0);
        run_bad(5'd12, 5'd12);
        // R12: reset during an outstanding request
        offer(2'd1, 1'b0, 2'd0, 64'h300, 64'h0, 16'h2, 5'd3, 5'd4);
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_req_valid === 1'b0 && op_ready === 1'b1 && done === 1'b0,
            "R12 reset mid-op", 64'({mem_req_valid, op_ready, done}), 64'b010);
        rst_n = 1'b1;
        @(negedge clk);
        run_ok(2'd2, 1'b1, 2'd0, 64'h400, 64'h0, 16'hFFFC, 5'd8, 5'd9,
               64'h0000_0000_8765_4321, 2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule